// File: doc/BRIEF.md
# Hardware/Software Event Bridge

This block sits between hardware state machines and a small microcontroller bus and carries events in both directions. An event is a strobe together with a byte value. On the hardware-to-software side each event is captured in a live register. It holds an occurrence flag, a sticky overrun flag and the most recent value. Software sees these registers only through a frozen snapshot, which it takes with a single command. Several events can then be tested together, and none of them changes between two reads.

Each incoming event is set up as polled or interrupt-driven, and it carries its own enable. Software clears an event by writing an acknowledge mask to a command word. On the software-to-hardware side, a bus write to an output register presents the byte on that channel's value lines. The channel's strobe is raised for exactly one cycle, so hand-written hardware can consume the event with no handshake.

Word map, 16-bit data. Addresses 0 to N_EV-1 are the per-event control/status words. Address N_EV is the write-only command word. Addresses N_EV+1 to N_EV+N_OUT are the output channels.

Top module: `hs_event_bridge`

## Requirements
- R1: After reset every occurrence, overrun and enable bit is 0, every event is in polled mode, `irq` is 0, every status word reads 0 and no output strobe is high.
- R2: A high `ev_stb[i]` at a clock edge sets the live occurrence flag of event i and loads `ev_val` slice i as its value. A strobe with no pending occurrence leaves overrun unchanged.
- R3: Writing the command word with bit 0 set copies, at that edge, the live occurrence, overrun and value of every event into the snapshot. Status words return the snapshot fields, so strobes and acknowledges made after the freeze stay invisible until the next freeze. The snapshot holds the state from before that edge's own strobes and acknowledges.
- R4: A strobe on event i while its live occurrence is set, and without an acknowledge in the same cycle, sets the sticky overrun bit and replaces the value with the newest one.
- R5: Writing the command word with bit 8+i set acknowledges event i and clears its live occurrence and overrun. A strobe in the same cycle as the acknowledge leaves the occurrence set, loads the new value and leaves overrun clear.
- R6: `irq` is high exactly while some event has its live occurrence set, mode bit set (interrupt) and enable bit set. Events in polled mode never drive `irq`.
- R7: A write to address N_EV+1+j puts data bits [15:8] on `out_val` slice j and raises `out_stb[j]` for exactly the one cycle after the write edge. Reading that address returns the value in bits [15:8].
- R8: `bus_rdata` is 0 while `bus_oe` is low. The command word and unmapped addresses read as 0.
- R9: Writing status word i stores data bit 1 as its mode (1 = interrupt) and data bit 3 as its enable. The word reads back as occurrence at bit 0, mode at bit 1, overrun at bit 2, enable at bit 3 and the value at bits [15:8], with bits [7:4] zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write enable, acted on at the clock edge |
| bus_oe | input | 1 | Output enable for read data |
| bus_rdata | output | 16 | Read data, combinational from address |
| irq | output | 1 | Interrupt request |
| ev_stb | input | N_EV | Hardware event strobes |
| ev_val | input | N_EV*8 | Hardware event values, byte per event |
| out_stb | output | N_OUT | One-cycle software event strobes |
| out_val | output | N_OUT*8 | Software event values |

## Verification
A wrong live occurrence flag first shows on `irq`, in the cycle after the faulty edge, but only for events in interrupt mode. A wrong flag on a polled event, or a wrong value or overrun bit, stays hidden until the next freeze and read. For this reason the stimulus freezes often and reads every word right after each freeze. Output-channel faults appear on `out_stb` and `out_val` one cycle after the write. The random mix deliberately puts acknowledges, strobes and freezes in the same cycle, so that the ordering rules of R3 and R5 are observed at the ports.

// File: rtl/hs_event_bridge.sv
`timescale 1ns/1ps
module hs_event_bridge #(
  parameter int N_EV   = 4,
  parameter int N_OUT  = 3,
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [15:0]           bus_wdata,
  input  logic                  bus_we,
  input  logic                  bus_oe,
  output logic [15:0]           bus_rdata,
  output logic                  irq,
  input  logic [N_EV-1:0]       ev_stb,
  input  logic [N_EV*8-1:0]     ev_val,
  output logic [N_OUT-1:0]      out_stb,
  output logic [N_OUT*8-1:0]    out_val
);
  localparam int VW     = 8;
  localparam int CMD_A  = N_EV;
  localparam int OUT_A  = N_EV + 1;

  logic [N_EV-1:0] occ, ovr, mode, en, f_occ, f_ovr;
  logic [VW-1:0]   val   [N_EV];
  logic [VW-1:0]   f_val [N_EV];
  logic [15:0]     rd;

  wire             cmd_wr = bus_we && (bus_addr == ADDR_W'(CMD_A));
  wire             freeze = cmd_wr && bus_wdata[0];
  wire [N_EV-1:0]  ack    = cmd_wr ? bus_wdata[8 +: N_EV] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ <= '0; ovr <= '0; mode <= '0; en <= '0;
      f_occ <= '0; f_ovr <= '0;
      for (int i = 0; i < N_EV; i++) begin
        val[i]   <= '0;
        f_val[i] <= '0;
      end
    end else begin
      if (freeze) begin
        f_occ <= occ;
        f_ovr <= ovr;
        for (int i = 0; i < N_EV; i++) f_val[i] <= val[i];
      end
      for (int i = 0; i < N_EV; i++) begin
        occ[i] <= ev_stb[i] | (occ[i] & ~ack[i]);
        ovr[i] <= ~ack[i] & (ovr[i] | (ev_stb[i] & occ[i]));
        if (ev_stb[i]) val[i] <= ev_val[i*VW +: VW];
        if (bus_we && bus_addr == ADDR_W'(i)) begin
          mode[i] <= bus_wdata[1];
          en[i]   <= bus_wdata[3];
        end
      end
    end
  end

  assign irq = |(occ & mode & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_stb <= '0;
      out_val <= '0;
    end else begin
      for (int j = 0; j < N_OUT; j++) begin
        out_stb[j] <= bus_we && (bus_addr == ADDR_W'(OUT_A + j));
        if (bus_we && bus_addr == ADDR_W'(OUT_A + j))
          out_val[j*VW +: VW] <= bus_wdata[15:8];
      end
    end
  end

  always_comb begin
    rd = '0;
    for (int i = 0; i < N_EV; i++)
      if (bus_addr == ADDR_W'(i))
        rd = {f_val[i], 4'b0000, en[i], f_ovr[i], mode[i], f_occ[i]};
    for (int j = 0; j < N_OUT; j++)
      if (bus_addr == ADDR_W'(OUT_A + j))
        rd = {out_val[j*VW +: VW], 8'h00};
  end

  assign bus_rdata = bus_oe ? rd : '0;

  // R8
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> bus_rdata == 16'h0000);

  // R6
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|ev_stb || bus_we));

  for (genvar i = 0; i < N_EV; i++) begin : g_ev_chk
    // R2
    set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stb[i] |=> occ[i] && val[i] == $past(ev_val[i*VW +: VW]));
    // R4
    ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_stb[i] && occ[i] && !ack[i]) |=> ovr[i]);
    // R5
    ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[i] && !ev_stb[i]) |=> !occ[i] && !ovr[i]);
    // R3
    frz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> f_occ[i] == $past(occ[i]) && f_val[i] == $past(val[i]));
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out_chk
    // R7
    out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(OUT_A + j)) |=>
        out_stb[j] && out_val[j*VW +: VW] == $past(bus_wdata[15:8]));
    // R7
    out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == ADDR_W'(OUT_A + j)) |=> !out_stb[j]);
  end
endmodule

// File: tb/hs_event_bridge_tb.sv
`timescale 1ns/1ps
module hs_event_bridge_tb;
  localparam int N = 4, M = 3, AW = 4;
  localparam int CMD = N, OUTA = N + 1;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic bus_we = 0, bus_oe = 0, irq;
  logic [N-1:0] ev_stb = '0;
  logic [N*8-1:0] ev_val = '0;
  logic [M-1:0] out_stb;
  logic [M*8-1:0] out_val;

  hs_event_bridge #(.N_EV(N), .N_OUT(M), .ADDR_W(AW)) u_dut (
    .clk, .rst_n, .bus_addr, .bus_wdata, .bus_we, .bus_oe, .bus_rdata, .irq,
    .ev_stb, .ev_val, .out_stb, .out_val);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [N-1:0] m_occ = '0, m_ovr = '0, m_mode = '0, m_en = '0, m_focc = '0, m_fovr = '0;
  logic [7:0] m_val [N];
  logic [7:0] m_fval [N];
  logic [7:0] m_out [M];
  logic [M-1:0] m_stb = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_word(input int i);
    return {m_fval[i], 4'b0000, m_en[i], m_fovr[i], m_mode[i], m_focc[i]};
  endfunction

  function automatic logic exp_irq();
    return |(m_occ & m_mode & m_en);
  endfunction

  task automatic step(input logic [N-1:0] s, input logic [N*8-1:0] v,
                      input logic w, input logic [AW-1:0] a, input logic [15:0] d);
    logic [N-1:0] n_occ, n_ovr, n_mode, n_en, n_focc, n_fovr;
    logic [7:0] n_val [N];
    logic [7:0] n_fval [N];
    logic frz;
    @(negedge clk);
    ev_stb = s; ev_val = v; bus_we = w; bus_addr = a; bus_wdata = d;
    frz = w && a == AW'(CMD) && d[0];
    n_focc = frz ? m_occ : m_focc;
    n_fovr = frz ? m_ovr : m_fovr;
    for (int i = 0; i < N; i++) begin
      logic ak;
      ak = w && a == AW'(CMD) && d[8+i];
      n_fval[i] = frz ? m_val[i] : m_fval[i];
      n_occ[i] = s[i] | (m_occ[i] & ~ak);
      n_ovr[i] = ~ak & (m_ovr[i] | (s[i] & m_occ[i]));
      n_val[i] = s[i] ? v[i*8 +: 8] : m_val[i];
      n_mode[i] = (w && a == AW'(i)) ? d[1] : m_mode[i];
      n_en[i]   = (w && a == AW'(i)) ? d[3] : m_en[i];
    end
    for (int j = 0; j < M; j++) begin
      m_stb[j] = w && a == AW'(OUTA + j);
      if (m_stb[j]) m_out[j] = d[15:8];
    end
    @(posedge clk);
    #1;
    m_occ = n_occ; m_ovr = n_ovr; m_mode = n_mode; m_en = n_en;
    m_focc = n_focc; m_fovr = n_fovr;
    for (int i = 0; i < N; i++) begin m_val[i] = n_val[i]; m_fval[i] = n_fval[i]; end
    ev_stb = '0; bus_we = 0;
    chk(irq == exp_irq(), "R6 irq", irq, exp_irq());
    chk(out_stb == m_stb, "R7 out_stb", out_stb, m_stb);
    for (int j = 0; j < M; j++)
      chk(out_val[j*8 +: 8] == m_out[j], "R7 out_val", out_val[j*8 +: 8], m_out[j]);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    bus_addr = a; bus_oe = 1;
    #1;
    chk(bus_rdata == exp, req, bus_rdata, exp);
    bus_oe = 0;
    #1;
    chk(bus_rdata == 16'h0, "R8 oe low", bus_rdata, 0);
  endtask

  task automatic read_all();
    for (int i = 0; i < N; i++) rd(AW'(i), exp_word(i), "R2/R3/R4/R5/R9 status");
    rd(AW'(CMD), 16'h0, "R8 command word");
    rd(AW'(15), 16'h0, "R8 unmapped");
    for (int j = 0; j < M; j++) rd(AW'(OUTA + j), {m_out[j], 8'h00}, "R7 readback");
  endtask

  task automatic freeze_read();
    step('0, '0, 1, AW'(CMD), 16'h0001);
    read_all();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) begin m_val[i] = 0; m_fval[i] = 0; end
    for (int j = 0; j < M; j++) m_out[j] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(irq == 0, "R1 irq", irq, 0);
    chk(out_stb == 0, "R1 out_stb", out_stb, 0);
    rst_n = 1;
    read_all();

    // R2 / R5: strobe, then ack+strobe same cycle keeps occurrence, no overrun
    step(4'b0001, 32'h0000_00A5, 0, '0, '0);
    step(4'b0001, 32'h0000_003C, 1, AW'(CMD), 16'h0100);
    freeze_read();
    chk(m_focc[0] && !m_fovr[0], "R5 model sanity", m_focc[0], 1);
    // R4 overrun
    step(4'b0010, 32'h0000_1100, 0, '0, '0);
    step(4'b0010, 32'h0000_2200, 0, '0, '0);
    freeze_read();
    // R5 plain ack clears
    step('0, '0, 1, AW'(CMD), 16'h0300);
    freeze_read();
    // R6 / R9 interrupt mode on event 2, event 3 polled
    step('0, '0, 1, AW'(2), 16'h000A);
    step(4'b1100, 32'h7700_6600, 0, '0, '0);
    chk(irq == 1, "R6 irq raised", irq, 1);
    step('0, '0, 1, AW'(CMD), 16'h0400);
    chk(irq == 0, "R6 irq cleared, polled event 3 pending", irq, 0);
    // R3 freeze with simultaneous strobe shows pre-edge state
    step(4'b0001, 32'h0000_00EE, 1, AW'(CMD), 16'h0001);
    read_all();
    // R7 back-to-back output writes
    step('0, '0, 1, AW'(OUTA), 16'h5A00);
    step('0, '0, 1, AW'(OUTA + 2), 16'hC300);
    step('0, '0, 0, '0, '0);
    read_all();

    // constrained random mix
    for (int k = 0; k < 600; k++) begin
      logic [N-1:0] s;
      logic [N*8-1:0] v;
      int op;
      s = N'($urandom & $urandom);
      v = $urandom;
      op = $urandom_range(0, 9);
      case (op)
        6: step(s, v, 1, AW'($urandom_range(0, N-1)), 16'($urandom));
        7: step(s, v, 1, AW'(CMD), {8'($urandom), 7'b0, 1'($urandom)});
        8: step(s, v, 1, AW'(OUTA + $urandom_range(0, M-1)), 16'($urandom));
        9: step(s, v, 1, AW'($urandom_range(0, 15)), 16'($urandom));
        default: step(s, v, 0, '0, '0);
      endcase
      if (k % 12 == 11) freeze_read();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule